// File: doc/BRIEF.md
# Shared-Bus Flash and PSRAM Access Sequencer

This block turns single requests from a host into pin-level cycles for a package in which a flash die and a pseudo-SRAM die share one 16-bit data bus and their low address lines. Each request is a word read or word write to the flash, a read or write to the PSRAM with per-byte lane enables, or a PSRAM sleep or wake command. The block drives the select, strobe and address-latch pins for both dies. At most one die is selected at any time. After each access, a turnaround gap passes before the next die may be selected.

Every bus access has four phases: setup, strobe, hold and turnaround. The length of each phase is a parameter counted in clock cycles. The defaults give a 100 ns strobe at 50 MHz, which covers an 85 ns random access. The host sees a ready signal that is high only when the block is idle. Each request ends with a one-cycle done pulse. Read data is returned with that pulse. An error flag comes with the pulse when a PSRAM access is refused because the PSRAM is asleep.

Top module: `mcp_bus_seq`

## Requirements
- R1: After reset, flash_ce_n, flash_adv_n, flash_oe_n, flash_we_n, ram_ce1_n, ram_oe_n, ram_we_n and every ram_be_n bit are high, ram_ce2 is high (PSRAM awake), bus_dq_oe is low and req_ready is high.
- R2: A flash read (req_op=2'b00, req_psram=0) returns the word stored at the full 23-bit address. flash_adv_n is low during setup and rises while flash_ce_n is still low.
- R3: In a flash write (req_op=2'b01), flash_we_n rises while flash_ce_n is still low, and bus_dq_oe is high at that edge. The word stored at the address equals req_wdata.
- R4: flash_ce_n low, ram_ce1_n low and ram_ce2 high never occur together, and enable_fault never asserts.
- R5: Between the deselect of one access and the select of the next, both dies stay deselected for at least T_TURN cycles. The design never drives bus_dq_oe while a die drives the bus.
- R6: req_be bit 0 enables the low byte (data 7:0, ram_be_n[0]) and bit 1 enables the high byte (data 15:8, ram_be_n[1]). A PSRAM write leaves a disabled lane unchanged. A PSRAM read returns zero in a disabled lane.
- R7: During a PSRAM access, bus_addr bits 22:21 are zero, so two request addresses that differ only in those bits reach the same PSRAM word.
- R8: req_op=2'b10 drives ram_ce2 low (sleep) and req_op=2'b11 drives it high (wake). Each completes with rsp_done in the cycle after it is accepted. Flash accesses still work while the PSRAM sleeps.
- R9: A PSRAM read or write while the PSRAM sleeps ends with rsp_done and rsp_err and never asserts ram_ce1_n. The PSRAM contents stay unchanged.
- R10: req_ready is low from the acceptance of a bus access until its turnaround ends. A request that is presented while req_ready is low has no effect.
- R11: Every flash access, including the first after reset, begins with a falling edge of flash_ce_n that comes together with a falling edge of flash_adv_n.
- R12: Each output or write strobe stays low for exactly T_STROBE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, so a request is taken |
| req_op | input | 2 | 00 read, 01 write, 10 PSRAM sleep, 11 PSRAM wake |
| req_psram | input | 1 | 1 targets the PSRAM, 0 targets the flash |
| req_addr | input | 23 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | PSRAM lane enables, bit 0 is the low byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | PSRAM access refused while asleep |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| bus_addr | output | 23 | Shared address lines |
| bus_dq_out | output | 16 | Data driven toward the dies |
| bus_dq_oe | output | 1 | Drive enable for bus_dq_out |
| bus_dq_in | input | 16 | Data returned by the dies |
| flash_ce_n | output | 1 | Flash select, active low |
| flash_adv_n | output | 1 | Flash address latch strobe, transparent when low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write strobe, active low |
| ram_ce1_n | output | 1 | PSRAM select, active low |
| ram_ce2 | output | 1 | PSRAM power enable, low means asleep |
| ram_oe_n | output | 1 | PSRAM output enable, active low |
| ram_we_n | output | 1 | PSRAM write strobe, active low |
| ram_be_n | output | 2 | PSRAM byte lane enables, active low |
| enable_fault | output | 1 | Forbidden select combination computed |

## Verification
The assertions rely on a few things about the inputs. The turnaround length is at least one cycle. bus_dq_in is driven only by the die whose select and output enable are low. Read and write requests to the PSRAM carry at least one lane enable. The stimulus keeps to these limits. It uses a small pool of addresses with random upper bits and random nonzero lane masks. Its flash and PSRAM models drive the data bus only when selected, and sleep and wake commands come in random order with accesses. It offers requests only while ready is high, except in one directed case that presents a write while an access is in progress.

// File: rtl/mcp_bus_pkg.sv
package mcp_bus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_STROBE = 3'd2,
      PH_HOLD   = 3'd3,
      PH_TURN   = 3'd4
   } phase_t;

   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_SLEEP = 2'b10,
      OP_WAKE  = 2'b11
   } op_t;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/mcp_phase_fsm.sv
module mcp_phase_fsm
   import mcp_bus_pkg::*;
#(
   parameter int T_SETUP  = 1,
   parameter int T_STROBE = 5,
   parameter int T_HOLD   = 1,
   parameter int T_TURN   = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output phase_t phase,
   output logic   last_strobe,
   output logic   last_hold
);
   localparam int MAXT = max4(T_SETUP, T_STROBE, T_HOLD, T_TURN);
   localparam int CW   = (MAXT < 2) ? 1 : $clog2(MAXT);

   generate
      if (T_SETUP < 1 || T_STROBE < 1 || T_HOLD < 1 || T_TURN < 1) begin : g_bad_timing
         $error("mcp_phase_fsm: every phase needs at least one cycle");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          cnt_zero;

   assign cnt_zero    = (cnt == '0);
   assign last_strobe = (phase == PH_STROBE) && cnt_zero;
   assign last_hold   = (phase == PH_HOLD) && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               phase <= PH_SETUP;
               cnt   <= CW'(T_SETUP - 1);
            end
            PH_SETUP: if (cnt_zero) begin
               phase <= PH_STROBE;
               cnt   <= CW'(T_STROBE - 1);
            end else cnt <= cnt - 1'b1;
            PH_STROBE: if (cnt_zero) begin
               phase <= PH_HOLD;
               cnt   <= CW'(T_HOLD - 1);
            end else cnt <= cnt - 1'b1;
            PH_HOLD: if (cnt_zero) begin
               phase <= PH_TURN;
               cnt   <= CW'(T_TURN - 1);
            end else cnt <= cnt - 1'b1;
            PH_TURN: if (cnt_zero) begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end else cnt <= cnt - 1'b1;
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   // R10: the block returns to idle only through the turnaround phase
   a_r10_idle_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && $past(phase) != PH_IDLE) |-> $past(phase) == PH_TURN);

   // R10: a new access starts only from idle
   a_r10_setup_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase == PH_SETUP) |-> $past(phase) == PH_IDLE);

endmodule

// File: rtl/mcp_pin_map.sv
module mcp_pin_map
   import mcp_bus_pkg::*;
#(
   parameter int ADDR_W     = 23,
   parameter int RAM_ADDR_W = 21,
   parameter int LANES      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_t            phase,
   input  logic              psram,
   input  logic              write,
   input  logic              sleep,
   input  logic [LANES-1:0]  be,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              dq_oe,
   output logic              flash_ce_n,
   output logic              flash_adv_n,
   output logic              flash_oe_n,
   output logic              flash_we_n,
   output logic              ram_ce1_n,
   output logic              ram_ce2,
   output logic              ram_oe_n,
   output logic              ram_we_n,
   output logic [LANES-1:0]  ram_be_n,
   output logic              fault
);
   logic sel, stb, f_sel, r_sel;

   always_comb begin
      sel   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
      stb   = (phase == PH_STROBE);
      f_sel = sel && !psram;
      r_sel = sel && psram && !sleep;

      flash_ce_n  = !f_sel;
      flash_adv_n = !(f_sel && phase == PH_SETUP);
      flash_oe_n  = !(f_sel && stb && !write);
      flash_we_n  = !(f_sel && stb && write);
      ram_ce1_n   = !r_sel;
      ram_ce2     = !sleep;
      ram_oe_n    = !(r_sel && stb && !write);
      ram_we_n    = !(r_sel && stb && write);
      dq_oe       = sel && write;
      fault       = !flash_ce_n && !ram_ce1_n && ram_ce2;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign ram_be_n[i] = !(r_sel && be[i]);
   end

   generate
      if (ADDR_W > RAM_ADDR_W) begin : g_split_addr
         assign bus_addr = psram ? {{(ADDR_W - RAM_ADDR_W){1'b0}}, addr[RAM_ADDR_W-1:0]} : addr;

         // R7: upper lines are parked at zero while the PSRAM is selected
         a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !ram_ce1_n |-> bus_addr[ADDR_W-1:RAM_ADDR_W] == '0);
      end else if (ADDR_W == RAM_ADDR_W) begin : g_same_addr
         assign bus_addr = addr;
      end else begin : g_bad_addr
         $error("mcp_pin_map: PSRAM address wider than the bus");
      end
   endgenerate

   // R4: never both dies active
   a_r4_one_die: assert property (@(posedge clk) disable iff (!rst_n)
      !(!flash_ce_n && !ram_ce1_n && ram_ce2));

   // R3: write strobe releases before the flash select
   a_r3_we_before_ce: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flash_we_n) |-> !flash_ce_n && dq_oe);

   // R2: latch closes while the flash is still selected
   a_r2_latch_in_select: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flash_adv_n) |-> !flash_ce_n);

   // R11: each flash select opens the address latch
   a_r11_adv_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flash_ce_n) |-> $fell(flash_adv_n));

   // R5: a deselect is followed by at least one idle-bus cycle
   a_r5_gap_flash: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flash_ce_n) |=> flash_ce_n && ram_ce1_n && !dq_oe);
   a_r5_gap_ram: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_ce1_n) |=> flash_ce_n && ram_ce1_n && !dq_oe);

   // R6: lane enables only inside a PSRAM select
   a_r6_lanes_in_select: assert property (@(posedge clk) disable iff (!rst_n)
      !(&ram_be_n) |-> !ram_ce1_n);

endmodule

// File: rtl/mcp_bus_seq.sv
module mcp_bus_seq
   import mcp_bus_pkg::*;
#(
   parameter int ADDR_W     = 23,
   parameter int RAM_ADDR_W = 21,
   parameter int DATA_W     = 16,
   parameter int T_SETUP    = 1,
   parameter int T_STROBE   = 5,
   parameter int T_HOLD     = 1,
   parameter int T_TURN     = 2,
   localparam int LANES     = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic              req_psram,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dq_out,
   output logic              bus_dq_oe,
   input  logic [DATA_W-1:0] bus_dq_in,
   output logic              flash_ce_n,
   output logic              flash_adv_n,
   output logic              flash_oe_n,
   output logic              flash_we_n,
   output logic              ram_ce1_n,
   output logic              ram_ce2,
   output logic              ram_oe_n,
   output logic              ram_we_n,
   output logic [LANES-1:0]  ram_be_n,
   output logic              enable_fault
);
   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
         $error("mcp_bus_seq: data width must be a whole number of bytes");
      end
   endgenerate

   phase_t            phase;
   logic              last_strobe, last_hold;
   logic              accept, is_access, asleep_hit, start;
   op_t               op;
   logic              sleep_q;
   logic              a_psram, a_write;
   logic [LANES-1:0]  a_be;
   logic [ADDR_W-1:0] a_addr;
   logic [DATA_W-1:0] a_wdata;
   logic [DATA_W-1:0] rd_masked;

   assign op         = op_t'(req_op);
   assign req_ready  = (phase == PH_IDLE);
   assign accept     = req_valid && req_ready;
   assign is_access  = (op == OP_READ) || (op == OP_WRITE);
   assign asleep_hit = is_access && req_psram && sleep_q;
   assign start      = accept && is_access && !asleep_hit;
   assign bus_dq_out = a_wdata;

   mcp_phase_fsm #(
      .T_SETUP (T_SETUP),
      .T_STROBE(T_STROBE),
      .T_HOLD  (T_HOLD),
      .T_TURN  (T_TURN)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .phase      (phase),
      .last_strobe(last_strobe),
      .last_hold  (last_hold)
   );

   mcp_pin_map #(
      .ADDR_W    (ADDR_W),
      .RAM_ADDR_W(RAM_ADDR_W),
      .LANES     (LANES)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .psram      (a_psram),
      .write      (a_write),
      .sleep      (sleep_q),
      .be         (a_be),
      .addr       (a_addr),
      .bus_addr   (bus_addr),
      .dq_oe      (bus_dq_oe),
      .flash_ce_n (flash_ce_n),
      .flash_adv_n(flash_adv_n),
      .flash_oe_n (flash_oe_n),
      .flash_we_n (flash_we_n),
      .ram_ce1_n  (ram_ce1_n),
      .ram_ce2    (ram_ce2),
      .ram_oe_n   (ram_oe_n),
      .ram_we_n   (ram_we_n),
      .ram_be_n   (ram_be_n),
      .fault      (enable_fault)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_rd_lane
      assign rd_masked[i*8 +: 8] = (a_psram && !a_be[i]) ? 8'h00 : bus_dq_in[i*8 +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_psram <= 1'b0;
         a_write <= 1'b0;
         a_be    <= '0;
         a_addr  <= '0;
         a_wdata <= '0;
      end else if (start) begin
         a_psram <= req_psram;
         a_write <= (op == OP_WRITE);
         a_be    <= req_psram ? req_be : {LANES{1'b1}};
         a_addr  <= req_addr;
         a_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_q   <= 1'b0;
         rsp_done  <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (accept && op == OP_SLEEP) sleep_q <= 1'b1;
         if (accept && op == OP_WAKE)  sleep_q <= 1'b0;
         rsp_done <= (accept && !start) || last_hold;
         rsp_err  <= accept && asleep_hit;
         if (last_strobe && !a_write) rsp_rdata <= rd_masked;
      end
   end

   // R9: no PSRAM select while asleep
   a_r9_asleep_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_ce2 |-> ram_ce1_n);

   // R9: a refusal is always reported with completion
   a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done);

   // R8: a sleep command takes effect on the next cycle
   a_r8_sleep_applies: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_SLEEP) |=> !ram_ce2);

   // R8: a wake command takes effect on the next cycle
   a_r8_wake_applies: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op == OP_WAKE) |=> ram_ce2);

   // R10: no new request while a die is selected
   a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_ce_n || !ram_ce1_n) |-> !req_ready);

endmodule

// File: tb/sim_mcp_bus_seq.sv
module sim_mcp_bus_seq;
   localparam int AW = 23, RAW = 21, DW = 16, LN = 2;
   localparam int TS = 1, TST = 5, TH = 1, TT = 2;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          req_valid = 1'b0, req_ready;
   logic [1:0]    req_op = 2'b00;
   logic          req_psram = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [LN-1:0] req_be = 2'b11;
   logic          rsp_done, rsp_err;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_dq_out, bus_dq_in;
   logic          bus_dq_oe;
   logic          flash_ce_n, flash_adv_n, flash_oe_n, flash_we_n;
   logic          ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n;
   logic [LN-1:0] ram_be_n;
   logic          enable_fault;

   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   mcp_bus_seq u0 (.*);

   // ---------------- die models ----------------
   logic [AW-1:0] flat;
   logic [15:0] fdev [logic [22:0]];
   logic [15:0] rdev [logic [20:0]];
   logic f_drv, r_drv;

   function automatic logic [15:0] frd(input logic [22:0] a);
      return fdev.exists(a) ? fdev[a] : 16'hFFFF;
   endfunction
   function automatic logic [15:0] rrd(input logic [20:0] a);
      return rdev.exists(a) ? rdev[a] : 16'h0000;
   endfunction

   always_latch if (!flash_adv_n) flat = bus_addr;

   assign f_drv = !flash_ce_n && !flash_oe_n;
   assign r_drv = !ram_ce1_n && ram_ce2 && !ram_oe_n;

   always @* begin
      logic [15:0] w;
      if (f_drv) bus_dq_in = frd(flat);
      else if (r_drv) begin
         w = rrd(bus_addr[20:0]);
         for (int i = 0; i < LN; i++) if (ram_be_n[i]) w[i*8 +: 8] = 8'hA5;
         bus_dq_in = w;
      end else bus_dq_in = 16'hDEAD;
   end

   always @(posedge flash_we_n) if (rst_n && !flash_ce_n) fdev[flat] = bus_dq_out;

   always @(posedge ram_we_n) begin
      logic [15:0] w;
      if (rst_n && !ram_ce1_n && ram_ce2) begin
         w = rrd(bus_addr[20:0]);
         for (int i = 0; i < LN; i++) if (!ram_be_n[i]) w[i*8 +: 8] = bus_dq_out[i*8 +: 8];
         rdev[bus_addr[20:0]] = w;
      end
   end

   // ---------------- bus monitors ----------------
   int fault_seen = 0, contention = 0, stb_bad = 0, stb_seen = 0, stb_len = 0;
   int gap = 1000, gap_bad = 0, r11_bad = 0, r11_seen = 0, adv_bad = 0, we_bad = 0;
   int addr_bad = 0, ram_sel_cnt = 0;
   logic pf_ce = 1'b1, pf_adv = 1'b1, pr_ce = 1'b1, pf_we = 1'b1, p_stb = 1'b0;

   always @(negedge clk) if (rst_n) begin
      logic stb;
      stb = !flash_oe_n || !flash_we_n || !ram_oe_n || !ram_we_n;
      if (enable_fault || (!flash_ce_n && !ram_ce1_n && ram_ce2)) fault_seen++;
      if ((bus_dq_oe && (f_drv || r_drv)) || (f_drv && r_drv)) contention++;
      if (stb) stb_len++;
      if (p_stb && !stb) begin
         stb_seen++;
         if (stb_len != TST) stb_bad++;
         stb_len = 0;
      end
      if ((!flash_ce_n && pf_ce && pr_ce) || (!ram_ce1_n && pr_ce && pf_ce))
         if (gap < TT) gap_bad++;
      if (flash_ce_n && ram_ce1_n && !bus_dq_oe) gap++; else gap = 0;
      if (!flash_ce_n && pf_ce) begin
         r11_seen++;
         if (!(!flash_adv_n && pf_adv)) r11_bad++;
      end
      if (flash_adv_n && !pf_adv && flash_ce_n) adv_bad++;
      if (flash_we_n && !pf_we && (flash_ce_n || !bus_dq_oe)) we_bad++;
      if (!ram_ce1_n && bus_addr[22:21] != 2'b00) addr_bad++;
      if (!ram_ce1_n && pr_ce) ram_sel_cnt++;
      pf_ce = flash_ce_n; pf_adv = flash_adv_n; pr_ce = ram_ce1_n; pf_we = flash_we_n; p_stb = stb;
   end

   // ---------------- reporting ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- host driver ----------------
   task automatic issue(input logic [1:0] op, input logic ps, input logic [22:0] a,
                        input logic [15:0] wd, input logic [1:0] be,
                        output logic [15:0] rd, output logic er);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_op = op; req_psram = ps; req_addr = a; req_wdata = wd; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_done) @(negedge clk);
      rd = rsp_rdata; er = rsp_err;
   endtask

   // bench reference contents
   logic [15:0] ef [logic [22:0]];
   logic [15:0] er_m [logic [20:0]];
   function automatic logic [15:0] ef_rd(input logic [22:0] a);
      return ef.exists(a) ? ef[a] : 16'hFFFF;
   endfunction
   function automatic logic [15:0] er_rd(input logic [20:0] a);
      return er_m.exists(a) ? er_m[a] : 16'h0000;
   endfunction
   function automatic logic [15:0] lane_mask(input logic [1:0] be);
      return {{8{be[1]}}, {8{be[0]}}};
   endfunction

   initial begin
      logic [15:0] rd;
      logic e;
      int sel0;
      bit asleep;
      void'($urandom(32'd9157));

      repeat (3) @(negedge clk);
      // R1: reset state
      check(flash_ce_n && flash_adv_n && flash_oe_n && flash_we_n, "R1", "flash pins idle",
            {flash_ce_n, flash_adv_n, flash_oe_n, flash_we_n}, 4'hF);
      check(ram_ce1_n && ram_oe_n && ram_we_n && (&ram_be_n) && ram_ce2, "R1", "ram pins idle",
            {ram_ce1_n, ram_oe_n, ram_we_n, ram_be_n, ram_ce2}, 6'h3F);
      check(!bus_dq_oe && req_ready, "R1", "bus released and ready", {bus_dq_oe, req_ready}, 2'b01);
      rst_n = 1'b1;

      // R11 / R2: first access after reset is a flash read of erased content
      issue(2'b00, 1'b0, 23'h000010, 16'h0, 2'b11, rd, e);
      check(rd == 16'hFFFF && !e, "R2", "erased flash read", rd, 16'hFFFF);
      check(r11_seen == 1 && r11_bad == 0, "R11", "first select opens latch", r11_bad, 0);

      // R3: flash write then read, high address bits in use
      issue(2'b01, 1'b0, 23'h400010, 16'h1234, 2'b11, rd, e); ef[23'h400010] = 16'h1234;
      issue(2'b00, 1'b0, 23'h400010, 16'h0, 2'b11, rd, e);
      check(rd == 16'h1234, "R3", "flash write readback", rd, 16'h1234);
      issue(2'b00, 1'b0, 23'h000010, 16'h0, 2'b11, rd, e);
      check(rd == 16'hFFFF, "R2", "neighbour untouched by bit 22", rd, 16'hFFFF);

      // R6: PSRAM word and byte lanes
      issue(2'b01, 1'b1, 23'h000040, 16'hBEEF, 2'b11, rd, e); er_m[21'h40] = 16'hBEEF;
      issue(2'b00, 1'b1, 23'h000040, 16'h0, 2'b11, rd, e);
      check(rd == 16'hBEEF, "R6", "psram word", rd, 16'hBEEF);
      issue(2'b01, 1'b1, 23'h000040, 16'h7711, 2'b01, rd, e); er_m[21'h40] = 16'hBE11;
      issue(2'b00, 1'b1, 23'h000040, 16'h0, 2'b10, rd, e);
      check(rd == 16'hBE00, "R6", "high lane read, low lane zero", rd, 16'hBE00);
      issue(2'b00, 1'b1, 23'h000040, 16'h0, 2'b01, rd, e);
      check(rd == 16'h0011, "R6", "low lane read after byte write", rd, 16'h0011);

      // R7: upper address bits do not reach the PSRAM
      issue(2'b00, 1'b1, 23'h600040, 16'h0, 2'b11, rd, e);
      check(rd == 16'hBE11, "R7", "alias through bits 22:21", rd, 16'hBE11);

      // R8 / R9: sleep, refused access, flash still served, wake
      issue(2'b10, 1'b0, 23'h0, 16'h0, 2'b11, rd, e);
      check(!ram_ce2 && !e, "R8", "sleep drives power enable low", ram_ce2, 1'b0);
      sel0 = ram_sel_cnt;
      issue(2'b01, 1'b1, 23'h000040, 16'h0000, 2'b11, rd, e);
      check(e == 1'b1, "R9", "write while asleep flagged", e, 1'b1);
      check(ram_sel_cnt == sel0, "R9", "no psram select while asleep", ram_sel_cnt, sel0);
      issue(2'b00, 1'b0, 23'h400010, 16'h0, 2'b11, rd, e);
      check(rd == 16'h1234 && !e, "R8", "flash read while psram asleep", rd, 16'h1234);
      issue(2'b11, 1'b0, 23'h0, 16'h0, 2'b11, rd, e);
      check(ram_ce2 == 1'b1, "R8", "wake drives power enable high", ram_ce2, 1'b1);
      issue(2'b00, 1'b1, 23'h000040, 16'h0, 2'b11, rd, e);
      check(rd == 16'hBE11 && !e, "R9", "contents kept through refusal", rd, 16'hBE11);

      // R10: a request offered while busy is ignored
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_op = 2'b00; req_psram = 1'b0; req_addr = 23'h000010;
      @(negedge clk);
      req_op = 2'b01; req_addr = 23'h000020; req_wdata = 16'h5555;
      check(!req_ready, "R10", "ready low during access", req_ready, 1'b0);
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_done) @(negedge clk);
      check(!req_ready, "R10", "ready low in turnaround", req_ready, 1'b0);
      issue(2'b00, 1'b0, 23'h000020, 16'h0, 2'b11, rd, e);
      check(rd == 16'hFFFF, "R10", "busy-time write had no effect", rd, 16'hFFFF);

      // random mix
      asleep = 1'b0;
      for (int n = 0; n < 300; n++) begin
         int r;
         logic ps;
         logic [22:0] a;
         logic [15:0] wd, exp;
         logic [1:0] be;
         r  = $urandom % 12;
         ps = $urandom % 2;
         a  = {2'($urandom % 4), 15'h0, 6'($urandom % 16)};
         wd = 16'($urandom);
         be = 2'($urandom % 3 + 1);
         if (r == 0) begin
            issue(asleep ? 2'b11 : 2'b10, 1'b0, a, wd, be, rd, e);
            asleep = !asleep;
            check(ram_ce2 == !asleep, "R8", "random sleep/wake", ram_ce2, !asleep);
         end else if (r < 6) begin
            issue(2'b01, ps, a, wd, be, rd, e);
            if (!ps) ef[a] = wd;
            else if (!asleep) er_m[a[20:0]] = (er_rd(a[20:0]) & ~lane_mask(be)) | (wd & lane_mask(be));
            check(e == (ps && asleep), "R9", "random write error flag", e, ps && asleep);
         end else begin
            issue(2'b00, ps, a, wd, be, rd, e);
            check(e == (ps && asleep), "R9", "random read error flag", e, ps && asleep);
            if (!ps) begin
               exp = ef_rd(a);
               check(rd == exp, "R2", "random flash read", rd, exp);
            end else if (!asleep) begin
               exp = er_rd(a[20:0]) & lane_mask(be);
               check(rd == exp, "R6", "random psram read", rd, exp);
            end
         end
      end

      repeat (5) @(negedge clk);
      check(fault_seen == 0, "R4", "forbidden select combination seen", fault_seen, 0);
      check(gap_bad == 0, "R5", "short turnaround count", gap_bad, 0);
      check(contention == 0, "R5", "bus contention count", contention, 0);
      check(r11_bad == 0 && r11_seen > 0, "R11", "selects without latch edge", r11_bad, 0);
      check(adv_bad == 0, "R2", "latch closed outside select", adv_bad, 0);
      check(we_bad == 0, "R3", "write strobe released after select", we_bad, 0);
      check(addr_bad == 0, "R7", "upper lines nonzero on psram", addr_bad, 0);
      check(stb_bad == 0 && stb_seen > 0, "R12", "strobe width mismatches", stb_bad, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule